// File: doc/BRIEF.md
# Hash Engine Block Fetch Sequencer

This block is the control core of a message-digest accelerator. A host programs it through a byte-wide command port. The port carries a 2-bit command code, a 16-bit address and an 8-bit data byte. Through it the host sets a 16-bit source address, a 16-bit destination address, a 16-bit message length and a byte-order mode, and then issues a start command.

Once started, the engine reads message blocks of 64 bytes from a byte-wide external memory, one byte per cycle. It packs each block into a 512-bit word in the selected byte order and passes that word to a combinational compression stub, which returns 160 bits. The engine keeps looping while the running count of bytes read is below the programmed length. When the loop ends, it stores the 20-byte digest at the destination address, one byte per cycle, and returns to idle.

The host polls a status byte to learn when the engine has finished. The stub stands in for the real compression rounds. Message padding is left to software.

Top module: `hash_fetch_seq`

## Requirements
- R1: After a synchronous active-low reset the engine is idle, the read-back byte is 0, both memory enables are low, the byte-order bit reads 1 (big-endian) and the address and length registers are 0.
- R2: A command code of 1 whose address lies in the window 0xFE00..0xFE0F loads the read-back byte on the next clock from the register at the low 4 address bits. The offsets are:
  - 0: status
  - 1: byte-order bit in bit 0
  - 2 and 3: source address low and high
  - 4 and 5: destination address low and high
  - 6 and 7: length low and high
  - 8..15: read as 0

  A read outside the window leaves the read-back byte unchanged.
- R3: A command code of 2 in the window updates the addressed register only while the engine is idle. Writes issued while it is busy leave every register unchanged.
- R4: Writing the value 1 to offset 0 while idle clears the bytes-read count and the running digest, and the engine enters the fetch state (1) on the next clock. Any other value written to offset 0 starts nothing.
- R5: In the fetch state the engine asserts the read enable for 64 consecutive cycles. Each cycle it presents address source + bytes-read + i, where i runs from 0 to 63 and the sum wraps at 16 bits. The byte returned in the same cycle is captured.
- R6: With the byte-order bit at 1, the first byte fetched lands in bits 511:504 of the block and the first byte stored is digest bits 159:152. With the bit at 0, the first byte fetched lands in bits 7:0 and the first byte stored is digest bits 7:0.
- R7: The engine spends one cycle in state 2 and then, in state 3, latches a new digest. Digest word i (bits 32i+31:32i, i = 0..4) becomes the old word i XOR every block word j (bits 32j+31:32j) whose index j satisfies j mod 5 = i.
- R8: Each block adds 64 to bytes-read. In state 3 the engine returns to state 1 if bytes-read < length and otherwise goes to state 4. A length of 0 therefore still processes exactly one block.
- R9: In state 4 the engine asserts the write enable for 20 consecutive cycles at destination + i, with i running from 0 to 19. It then returns to idle.
- R10: A status read returns the current state zero-extended to 8 bits, always one of 0..4, so the host can poll for completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cmd | input | 2 | Host command: 1 read, 2 write, others no operation |
| host_addr | input | 16 | Host register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read-back byte |
| mem_addr | output | 16 | External memory byte address |
| mem_rd_en | output | 1 | Memory read strobe, data expected in the same cycle |
| mem_rdata | input | 8 | Memory read byte |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |

## Verification
The bench runs one-block, three-block and zero-length jobs. A design whose loop compared the count before advancing it, or used "less or equal", would fetch one block too many or too few and produce a different digest. One job starts at 0xFFE0, so its fetch wraps the 16-bit address. A design that carried into a wider sum would read the wrong bytes. The byte order flips between jobs, so a lane index or a store index reversed in only one direction shows up as permuted digest bytes. A register write issued mid-job, and a start write with a value other than 1, must both leave visible state untouched when read back afterwards.

// File: rtl/hfs_pkg.sv
// Shared types and constants of the hash fetch sequencer.
package hfs_pkg;

    // Engine phases; values are visible to the host through the status byte.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_HASH  = 3'd2,
        ST_LATCH = 3'd3,
        ST_STORE = 3'd4
    } hfs_state_e;

    localparam logic [1:0] CMD_READ  = 2'd1;
    localparam logic [1:0] CMD_WRITE = 2'd2;

    localparam int unsigned OFS_W = 4;
    localparam logic [OFS_W-1:0] OFS_STATUS = 4'd0;
    localparam logic [OFS_W-1:0] OFS_ORDER  = 4'd1;
    localparam logic [OFS_W-1:0] OFS_SRC_LO = 4'd2;
    localparam logic [OFS_W-1:0] OFS_SRC_HI = 4'd3;
    localparam logic [OFS_W-1:0] OFS_DST_LO = 4'd4;
    localparam logic [OFS_W-1:0] OFS_DST_HI = 4'd5;
    localparam logic [OFS_W-1:0] OFS_LEN_LO = 4'd6;
    localparam logic [OFS_W-1:0] OFS_LEN_HI = 4'd7;

endpackage

// File: rtl/hfs_regfile.sv
// Host register file: decodes the byte command port, holds the job
// parameters and produces the start pulse.
// Assumes host_addr is 16 bits and the window spans 16 byte offsets.
module hfs_regfile
    import hfs_pkg::*;
#(
    parameter logic [15:0] WIN_BASE = 16'hFE00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  host_cmd,
    input  logic [15:0] host_addr,
    input  logic [7:0]  host_wdata,
    input  hfs_state_e  state_i,
    output logic [7:0]  host_rdata,
    output logic        big_o,
    output logic [15:0] src_o,
    output logic [15:0] dst_o,
    output logic [15:0] len_o,
    output logic        start_o
);

    logic             in_win;
    logic [OFS_W-1:0] ofs;
    logic             wr_ok;
    logic             rd_ok;
    logic [7:0]       rd_mux;

    // Window hit and offset extraction.
    assign in_win  = (host_addr[15:OFS_W] == WIN_BASE[15:OFS_W]);
    assign ofs     = host_addr[OFS_W-1:0];
    assign wr_ok   = (host_cmd == CMD_WRITE) && in_win && (state_i == ST_IDLE);
    assign rd_ok   = (host_cmd == CMD_READ) && in_win;
    assign start_o = wr_ok && (ofs == OFS_STATUS) && (host_wdata == 8'd1);

    // Register writes, accepted only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            big_o <= 1'b1;
            src_o <= '0;
            dst_o <= '0;
            len_o <= '0;
        end else if (wr_ok) begin
            case (ofs)
                OFS_ORDER:  big_o       <= host_wdata[0];
                OFS_SRC_LO: src_o[7:0]  <= host_wdata;
                OFS_SRC_HI: src_o[15:8] <= host_wdata;
                OFS_DST_LO: dst_o[7:0]  <= host_wdata;
                OFS_DST_HI: dst_o[15:8] <= host_wdata;
                OFS_LEN_LO: len_o[7:0]  <= host_wdata;
                OFS_LEN_HI: len_o[15:8] <= host_wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer over the register offsets.
    always_comb begin
        case (ofs)
            OFS_STATUS: rd_mux = {5'd0, state_i};
            OFS_ORDER:  rd_mux = {7'd0, big_o};
            OFS_SRC_LO: rd_mux = src_o[7:0];
            OFS_SRC_HI: rd_mux = src_o[15:8];
            OFS_DST_LO: rd_mux = dst_o[7:0];
            OFS_DST_HI: rd_mux = dst_o[15:8];
            OFS_LEN_LO: rd_mux = len_o[7:0];
            OFS_LEN_HI: rd_mux = len_o[15:8];
            default:    rd_mux = 8'd0;
        endcase
    end

    // Registered read-back byte; held when no in-window read occurs.
    always_ff @(posedge clk) begin
        if (!rst_n)     host_rdata <= '0;
        else if (rd_ok) host_rdata <= rd_mux;
    end

endmodule

// File: rtl/hfs_ctrl.sv
// Phase controller: walks idle -> fetch -> hash -> latch -> (fetch | store)
// -> idle. It keeps the byte index within a block or digest and the running
// bytes-read count. Assumes DIGEST_BYTES <= BLOCK_BYTES and a length that
// stays clear of 16-bit wrap of the bytes-read count.
module hfs_ctrl
    import hfs_pkg::*;
#(
    parameter int unsigned BLOCK_BYTES  = 64,
    parameter int unsigned DIGEST_BYTES = 20,
    localparam int unsigned IDX_W       = $clog2(BLOCK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      len_i,
    output hfs_state_e       state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [15:0]      bytes_read_o
);

    localparam logic [IDX_W-1:0] LAST_FETCH = IDX_W'(BLOCK_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_STORE = IDX_W'(DIGEST_BYTES - 1);
    localparam logic [15:0]      BLK_STEP   = 16'(BLOCK_BYTES);

    hfs_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [15:0]      br_q;
    logic             more;

    // Loop decision on the already advanced count.
    assign more = (br_q < len_i);

    // Phase, index and bytes-read sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            br_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_FETCH;
                        idx_q   <= '0;
                        br_q    <= '0;
                    end
                end
                ST_FETCH: begin
                    if (idx_q == LAST_FETCH) begin
                        state_q <= ST_HASH;
                        idx_q   <= '0;
                        br_q    <= br_q + BLK_STEP;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_HASH:  state_q <= ST_LATCH;
                ST_LATCH: begin
                    state_q <= more ? ST_FETCH : ST_STORE;
                    idx_q   <= '0;
                end
                ST_STORE: begin
                    if (idx_q == LAST_STORE) begin
                        state_q <= ST_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o      = state_q;
    assign idx_o        = idx_q;
    assign bytes_read_o = br_q;

    // A start in idle opens a fresh fetch with a cleared count.
    assert_start_enters_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q == ST_IDLE) |=> (state_q == ST_FETCH && br_q == 16'd0));

    // Loop back while bytes remain.
    assert_loop_more_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && br_q < len_i) |=> (state_q == ST_FETCH));

    // Otherwise move on to write-back.
    assert_loop_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && br_q >= len_i) |=> (state_q == ST_STORE));

    // Each completed block advances the count by one block.
    assert_block_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && idx_q == LAST_FETCH) |=> (br_q == $past(br_q) + BLK_STEP));

    // Only the five defined phases ever appear.
    assert_state_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_IDLE, ST_FETCH, ST_HASH, ST_LATCH, ST_STORE}));

endmodule

// File: rtl/hfs_block_pack.sv
// Block assembler: places each fetched byte into its lane of the block word.
// Big-endian puts fetch index 0 in the top lane, little-endian in lane 0.
// Assumes idx_i counts 0..BLOCK_BYTES-1 while load_i is high.
module hfs_block_pack #(
    parameter int unsigned BLOCK_BYTES = 64,
    localparam int unsigned IDX_W      = $clog2(BLOCK_BYTES),
    localparam int unsigned BLOCK_BITS = BLOCK_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  big_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [7:0]            byte_i,
    output logic [BLOCK_BITS-1:0] block_o
);

    for (genvar k = 0; k < BLOCK_BYTES; k++) begin : g_lane
        localparam logic [IDX_W-1:0] BIG_IDX = IDX_W'(BLOCK_BYTES - 1 - k);
        localparam logic [IDX_W-1:0] LIT_IDX = IDX_W'(k);
        logic [7:0] lane_q;
        logic       hit;

        assign hit = load_i && (idx_i == (big_i ? BIG_IDX : LIT_IDX));

        // Capture the byte whose index maps to this lane.
        always_ff @(posedge clk) begin
            if (!rst_n)   lane_q <= '0;
            else if (hit) lane_q <= byte_i;
        end

        assign block_o[k*8 +: 8] = lane_q;
    end

endmodule

// File: rtl/hfs_digest_stub.sv
// Combinational stand-in for the compression function: folds the block's
// 32-bit words onto the digest words by index modulo the digest word count
// and XORs the fold into the chaining value.
module hfs_digest_stub #(
    parameter int unsigned BLOCK_BITS  = 512,
    parameter int unsigned DIGEST_BITS = 160,
    parameter int unsigned WORD_W      = 32,
    localparam int unsigned NWORDS     = BLOCK_BITS / WORD_W,
    localparam int unsigned DWORDS     = DIGEST_BITS / WORD_W
) (
    input  logic [BLOCK_BITS-1:0]  block_i,
    input  logic [DIGEST_BITS-1:0] chain_i,
    output logic [DIGEST_BITS-1:0] digest_o
);

    for (genvar i = 0; i < DWORDS; i++) begin : g_word
        logic [WORD_W-1:0] acc;

        // XOR every block word whose index falls on this digest word.
        always_comb begin
            acc = '0;
            for (int j = 0; j < NWORDS; j++) begin
                if ((j % DWORDS) == i) acc = acc ^ block_i[j*WORD_W +: WORD_W];
            end
        end

        assign digest_o[i*WORD_W +: WORD_W] = chain_i[i*WORD_W +: WORD_W] ^ acc;
    end

endmodule

// File: rtl/hash_fetch_seq.sv
// Top of the hash fetch sequencer. Joins the host register file, the phase
// controller, the block assembler and the compression stub, and holds the
// running digest. Also drives the byte-wide memory port.
// Assumes memory returns read data combinationally in the cycle of the address.
module hash_fetch_seq
    import hfs_pkg::*;
#(
    parameter logic [15:0] WIN_BASE     = 16'hFE00,
    parameter int unsigned BLOCK_BYTES  = 64,
    parameter int unsigned DIGEST_BYTES = 20,
    localparam int unsigned IDX_W       = $clog2(BLOCK_BYTES),
    localparam int unsigned BLOCK_BITS  = BLOCK_BYTES * 8,
    localparam int unsigned DIGEST_BITS = DIGEST_BYTES * 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  host_cmd,
    input  logic [15:0] host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic [15:0] mem_addr,
    output logic        mem_rd_en,
    input  logic [7:0]  mem_rdata,
    output logic        mem_wr_en,
    output logic [7:0]  mem_wdata
);

    hfs_state_e             state;
    logic [IDX_W-1:0]       idx;
    logic [15:0]            bytes_read;
    logic                   big;
    logic [15:0]            src;
    logic [15:0]            dst;
    logic [15:0]            len;
    logic                   start;
    logic [BLOCK_BITS-1:0]  block;
    logic [DIGEST_BITS-1:0] stub_out;
    logic [DIGEST_BITS-1:0] digest_q;

    hfs_regfile #(.WIN_BASE(WIN_BASE)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cmd   (host_cmd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .state_i    (state),
        .host_rdata (host_rdata),
        .big_o      (big),
        .src_o      (src),
        .dst_o      (dst),
        .len_o      (len),
        .start_o    (start)
    );

    hfs_ctrl #(.BLOCK_BYTES(BLOCK_BYTES), .DIGEST_BYTES(DIGEST_BYTES)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .len_i        (len),
        .state_o      (state),
        .idx_o        (idx),
        .bytes_read_o (bytes_read)
    );

    hfs_block_pack #(.BLOCK_BYTES(BLOCK_BYTES)) pack_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (state == ST_FETCH),
        .big_i   (big),
        .idx_i   (idx),
        .byte_i  (mem_rdata),
        .block_o (block)
    );

    hfs_digest_stub #(.BLOCK_BITS(BLOCK_BITS), .DIGEST_BITS(DIGEST_BITS)) stub_i (
        .block_i  (block),
        .chain_i  (digest_q),
        .digest_o (stub_out)
    );

    // Running digest: cleared on start, updated once per block.
    always_ff @(posedge clk) begin
        if (!rst_n)                  digest_q <= '0;
        else if (start)              digest_q <= '0;
        else if (state == ST_LATCH)  digest_q <= stub_out;
    end

    // Memory address and strobes by phase.
    assign mem_rd_en = (state == ST_FETCH);
    assign mem_wr_en = (state == ST_STORE);
    always_comb begin
        if (state == ST_FETCH) mem_addr = src + bytes_read + 16'(idx);
        else                   mem_addr = dst + 16'(idx);
    end

    // Pick the digest byte for the current store index in the selected order.
    always_comb begin
        mem_wdata = '0;
        for (int k = 0; k < DIGEST_BYTES; k++) begin
            if (idx == IDX_W'(big ? (DIGEST_BYTES - 1 - k) : k)) mem_wdata = digest_q[k*8 +: 8];
        end
    end

    // Fetch addresses step by one within a block.
    assert_fetch_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // Store addresses step by one within the write-back.
    assert_store_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // Never read and write memory in the same cycle.
    assert_port_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // Job parameters hold while busy.
    assert_busy_len_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(len) && $stable(src) && $stable(dst)));

    assert_busy_order_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(big));

endmodule

// File: tb/hash_fetch_seq_tb.sv
`timescale 1ns/1ps
module hash_fetch_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  host_cmd;
    logic [15:0] host_addr;
    logic [7:0]  host_wdata;
    logic [7:0]  host_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rdata;
    logic        mem_wr_en;
    logic [7:0]  mem_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] mem [0:65535];

    always #10 clk = ~clk;

    hash_fetch_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cmd   (host_cmd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mem_addr   (mem_addr),
        .mem_rd_en  (mem_rd_en),
        .mem_rdata  (mem_rdata),
        .mem_wr_en  (mem_wr_en),
        .mem_wdata  (mem_wdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr_en) mem[mem_addr] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Fold of R7: digest word i gathers block words j with j mod 5 == i.
    function automatic logic [159:0] fold(input logic [511:0] b);
        logic [159:0] r = '0;
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 16; j++)
                if (j % 5 == i) r[i*32 +: 32] ^= b[j*32 +: 32];
        return r;
    endfunction

    function automatic logic [7:0] byte_of(input logic [159:0] d, input int i, input bit big);
        return big ? d[(19 - i)*8 +: 8] : d[i*8 +: 8];
    endfunction

    // Independent digest of a whole job from memory contents.
    function automatic logic [159:0] job_digest(input logic [15:0] src, input int len, input bit big);
        logic [159:0] d = '0;
        int nblk = (len == 0) ? 1 : (len + 63) / 64;
        for (int b = 0; b < nblk; b++) begin
            logic [511:0] w = '0;
            for (int k = 0; k < 64; k++) begin
                logic [15:0] a = src + 16'(b*64 + k);
                if (big) w[(63 - k)*8 +: 8] = mem[a];
                else     w[k*8 +: 8]        = mem[a];
            end
            d ^= fold(w);
        end
        return d;
    endfunction

    // ---------------- behavioural reference model ----------------
    int          m_st, m_idx, m_off;
    bit          m_big, m_inw;
    logic [15:0] m_br, m_src, m_dst, m_len, m_a;
    logic [7:0]  m_rd;
    logic [7:0]  m_q[$];
    logic [159:0] m_dig;
    logic [511:0] m_blk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_br = 0; m_src = 0; m_dst = 0; m_len = 0;
            m_big = 1'b1; m_rd = 0; m_q.delete(); m_dig = 0;
        end else begin
            m_off = int'(host_addr[3:0]);
            m_inw = (host_addr[15:4] == 12'hFE0);
            if (host_cmd == 2'd1 && m_inw) begin
                case (m_off)
                    0: m_rd = 8'(m_st);
                    1: m_rd = {7'd0, m_big};
                    2: m_rd = m_src[7:0];
                    3: m_rd = m_src[15:8];
                    4: m_rd = m_dst[7:0];
                    5: m_rd = m_dst[15:8];
                    6: m_rd = m_len[7:0];
                    7: m_rd = m_len[15:8];
                    default: m_rd = 8'd0;
                endcase
            end
            case (m_st)
                0: if (host_cmd == 2'd2 && m_inw) begin
                    case (m_off)
                        0: if (host_wdata == 8'd1) begin
                            m_st = 1; m_idx = 0; m_br = 0; m_dig = 0; m_q.delete();
                        end
                        1: m_big = host_wdata[0];
                        2: m_src[7:0]  = host_wdata;
                        3: m_src[15:8] = host_wdata;
                        4: m_dst[7:0]  = host_wdata;
                        5: m_dst[15:8] = host_wdata;
                        6: m_len[7:0]  = host_wdata;
                        7: m_len[15:8] = host_wdata;
                        default: ;
                    endcase
                end
                1: begin
                    m_a = m_src + m_br + 16'(m_idx);
                    m_q.push_back(mem[m_a]);
                    m_idx++;
                    if (m_idx == 64) begin m_idx = 0; m_br = m_br + 16'd64; m_st = 2; end
                end
                2: m_st = 3;
                3: begin
                    m_blk = '0;
                    for (int k = 0; k < 64; k++) begin
                        if (m_big) m_blk[(63 - k)*8 +: 8] = m_q[k];
                        else       m_blk[k*8 +: 8]        = m_q[k];
                    end
                    m_dig = m_dig ^ fold(m_blk);
                    m_q.delete();
                    m_st = (m_br < m_len) ? 1 : 4;
                end
                4: begin
                    m_idx++;
                    if (m_idx == 20) begin m_idx = 0; m_st = 0; end
                end
                default: ;
            endcase
        end
    end

    // Lockstep comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 read-back byte", 32'(host_rdata), 32'(m_rd));
            chk("R5 read enable", 32'(mem_rd_en), 32'(m_st == 1));
            chk("R9 write enable", 32'(mem_wr_en), 32'(m_st == 4));
            if (m_st == 1) chk("R5 fetch address", 32'(mem_addr), 32'(16'(m_src + m_br + 16'(m_idx))));
            if (m_st == 4) begin
                chk("R9 store address", 32'(mem_addr), 32'(16'(m_dst + 16'(m_idx))));
                chk("R6 R7 store byte", 32'(mem_wdata), 32'(byte_of(m_dig, m_idx, m_big)));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic host_op(input logic [1:0] c, input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        host_cmd = c; host_addr = a; host_wdata = d;
        @(posedge clk); #2;
        host_cmd = 2'd0;
    endtask

    task automatic wr(input int ofs, input logic [7:0] d);
        host_op(2'd2, 16'hFE00 + 16'(ofs), d);
    endtask

    task automatic rd(input int ofs, output logic [7:0] v);
        host_op(2'd1, 16'hFE00 + 16'(ofs), 8'd0);
        @(negedge clk);
        v = host_rdata;
    endtask

    task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [15:0] l, input bit big);
        wr(1, {7'd0, big});
        wr(2, s[7:0]); wr(3, s[15:8]);
        wr(4, d[7:0]); wr(5, d[15:8]);
        wr(6, l[7:0]); wr(7, l[15:8]);
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int n = 0; n < 3000; n++) begin
            rd(0, v);
            if (v == 8'd0) break;
            chk("R10 busy status range", 32'(v >= 8'd1 && v <= 8'd4), 32'd1);
        end
    endtask

    task automatic check_mem(input string req, input logic [15:0] s, input logic [15:0] d, input int l, input bit big);
        logic [159:0] e = job_digest(s, l, big);
        for (int i = 0; i < 20; i++) chk(req, 32'(mem[d + 16'(i)]), 32'(byte_of(e, i, big)));
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 65536; i++) mem[i] = 8'((i * 37) ^ (i >> 7) ^ 8'h5A);
        rst_n = 1'b0; host_cmd = 2'd0; host_addr = 16'd0; host_wdata = 8'd0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset read-back", 32'(host_rdata), 32'd0);
        chk("R1 reset read enable", 32'(mem_rd_en), 32'd0);
        chk("R1 reset write enable", 32'(mem_wr_en), 32'd0);
        rd(1, v); chk("R1 reset order bit", 32'(v), 32'd1);
        rd(0, v); chk("R1 reset status", 32'(v), 32'd0);
        rd(6, v); chk("R1 reset length", 32'(v), 32'd0);

        // Job A: big-endian, one block.
        setup(16'h1000, 16'h2000, 16'd64, 1'b1);
        rd(3, v); chk("R2 source high", 32'(v), 32'h10);
        rd(5, v); chk("R2 destination high", 32'(v), 32'h20);
        rd(6, v); chk("R2 length low", 32'(v), 32'd64);
        rd(4'hA, v); chk("R2 unmapped offset", 32'(v), 32'd0);
        rd(3, v);
        host_op(2'd1, 16'h1234, 8'd0);
        @(negedge clk); chk("R2 out-of-window read holds", 32'(host_rdata), 32'h10);
        wr(0, 8'd2);
        rd(0, v); chk("R4 value 2 does not start", 32'(v), 32'd0);
        wr(0, 8'd1);
        rd(0, v); chk("R4 R10 status after start", 32'(v), 32'd1);
        wr(6, 8'hEE);
        wr(1, 8'd0);
        wait_idle();
        rd(6, v); chk("R3 busy length write ignored", 32'(v), 32'd64);
        rd(1, v); chk("R3 busy order write ignored", 32'(v), 32'd1);
        check_mem("R6 R7 R9 big-endian one block", 16'h1000, 16'h2000, 64, 1'b1);

        // Job B: little-endian, three blocks, source wraps at 16 bits.
        setup(16'hFFE0, 16'h3000, 16'd130, 1'b0);
        wr(0, 8'd1);
        wait_idle();
        check_mem("R5 R6 R8 little-endian three blocks", 16'hFFE0, 16'h3000, 130, 1'b0);

        // Job C: zero length still processes one block.
        setup(16'h4000, 16'h5000, 16'd0, 1'b1);
        wr(0, 8'd1);
        wait_idle();
        check_mem("R8 zero length one block", 16'h4000, 16'h5000, 0, 1'b1);

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule